// File: doc/BRIEF.md
# Write-Only Two-Wire Configuration Slave

This block is a receive-only slave on a two-wire serial bus (I2C). It oversamples the bus clock and data lines with a fast system clock, passes each through a synchroniser and a glitch filter, and recognises START, repeated START and STOP. It collects an address byte and data bytes MSB first and answers each accepted byte by pulling the data line low through an open-drain enable. It never drives read data.

A write carries two data bytes after the address: a register pointer, then a value. The pair is held as a pending write and lands in a five-entry configuration file (four gain registers and one mode register) only when a valid STOP closes the transfer. Holding the bus clock low for a long time puts the block into a hardware-strap state in which the serial port is idle and any half-finished write is thrown away.

Top module: `i2cw_slave`

## Requirements
- R1: After reset the four gain registers read 0x0B, the mode register reads 0x00, the data line is released and the hardware-strap flag is low.
- R2: An address byte of 0x40 (seven address bits 0x20, R/W bit 0) is acknowledged; any address byte whose upper seven bits differ is not acknowledged and the transfer has no effect on the registers.
- R3: A pointer/value pair is not visible on the register outputs after the value byte's acknowledge; it appears only after the STOP that ends the transfer.
- R4: An address byte of 0x41 (R/W bit 1) is acknowledged, after which the slave leaves the data line released so the master reads 0xFF.
- R5: A pointer above 0x04 is acknowledged together with its value byte, and the STOP leaves all five registers unchanged.
- R6: A repeated START before STOP discards the pending pointer/value pair.
- R7: A STOP that falls in the same SCL high period as a START is ignored, and the transfer begun by that START continues normally.
- R8: A pulse on SDA shorter than FILT_LEN system clocks while SCL is high is neither a START nor a STOP.
- R9: When the filtered SCL stays low for more than HW_TIMEOUT clocks the strap flag rises, the data line is released, any pending write is dropped and SDA toggles have no effect; the flag clears when SCL returns high and later transfers work.
- R10: The acknowledge pull-down is applied and released only while the filtered SCL is low, so it spans the whole ninth-clock high period.
- R11: Bits are taken MSB first; pointer 0x00 to 0x03 selects gain register 0 to 3 (gainOut bits [8i+7:8i]) and pointer 0x04 selects the mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaPullLow | output | 1 | Open-drain enable: 1 pulls the data line low |
| hwMode | output | 1 | High while the port is in the hardware-strap state |
| gainOut | output | NUM_GAIN*8 | Gain registers, register i in bits [8i+7:8i] |
| modeOut | output | 8 | Mode register |

## Verification
The hardest situations to reach from the pins are the ones defined by the timing of SDA against a single SCL high period: a STOP that shares its high pulse with a START, and a spike that would form a false START followed by a false STOP. The bench drives both lines cycle by cycle, so it can place a START and an SDA rise inside one high pulse and follow it with a real address byte, and it can inject a sub-filter spike between the value byte and the real STOP so that a missing filter shows up as a dropped write. The strap state is reached mid-transfer by parking SCL low past the timeout while toggling SDA, and then issuing a STOP that must not commit.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_READ,
    ST_SKIP
  } busState_t;

  // Strobes from the bus controller to the register datapath
  typedef struct packed {
    logic shiftEn;
    logic bitIn;
    logic loadPtr;
    logic loadVal;
    logic dropPend;
    logic commit;
  } dpCmd_t;

endpackage

// File: rtl/i2cw_line_filter.sv
module i2cw_line_filter #(
  parameter int FILT_LEN = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineOut
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic syncA, syncB;
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= 1'b1;
      syncB   <= 1'b1;
      runCnt  <= '0;
      lineOut <= 1'b1;
    end else begin
      syncA <= lineIn;
      syncB <= syncA;
      if (syncB == lineOut) begin
        runCnt <= '0;
      end else if (runCnt == CW'(FILT_LEN - 1)) begin
        lineOut <= syncB;
        runCnt  <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cw_bus_ctrl.sv
module i2cw_bus_ctrl
  import i2cw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h20,
  parameter int         HW_TIMEOUT = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclF,
  input  logic       sdaF,
  input  logic [7:0] rxByte,
  output dpCmd_t     cmd,
  output logic       sdaPullLow,
  output logic       hwMode
);
  localparam int         LW   = $clog2(HW_TIMEOUT + 1);
  localparam logic [3:0] BITS = 4'd8;

  busState_t st, stN;
  logic [3:0] bitCnt, bitN;
  logic [1:0] byteIdx, idxN;
  logic       ackPhase, ackN;
  logic       startInPulse, sipN;
  logic       sclP, sdaP;
  logic [LW-1:0] lowCnt;

  logic sclRise, sclFall, startEv, stopEv;
  assign sclRise = sclF & ~sclP;
  assign sclFall = ~sclF & sclP;
  assign startEv = sclF & sclP & sdaP & ~sdaF;
  assign stopEv  = sclF & sclP & ~sdaP & sdaF;

  always_comb begin
    stN  = st;
    bitN = bitCnt;
    idxN = byteIdx;
    ackN = ackPhase;
    sipN = startInPulse;
    cmd  = '0;
    cmd.bitIn = sdaF;
    if (sclFall) sipN = 1'b0;
    if (hwMode) begin
      stN  = ST_IDLE;
      bitN = '0;
      ackN = 1'b0;
      cmd.dropPend = 1'b1;
    end else if (startEv) begin
      stN  = ST_ADDR;
      bitN = '0;
      idxN = '0;
      ackN = 1'b0;
      sipN = 1'b1;
      cmd.dropPend = 1'b1;
    end else if (stopEv && !startInPulse) begin
      stN  = ST_IDLE;
      bitN = '0;
      ackN = 1'b0;
      cmd.commit = 1'b1;
    end else if (sclRise) begin
      if ((st == ST_ADDR || st == ST_DATA) && !ackPhase && bitCnt < BITS) begin
        cmd.shiftEn = 1'b1;
        bitN = bitCnt + 1'b1;
      end
    end else if (sclFall) begin
      if (ackPhase) begin
        ackN = 1'b0;
        bitN = '0;
      end else if (bitCnt == BITS) begin
        case (st)
          ST_ADDR: begin
            if (rxByte[7:1] == DEV_ADDR) begin
              ackN = 1'b1;
              stN  = rxByte[0] ? ST_READ : ST_DATA;
            end else begin
              stN = ST_SKIP;
            end
          end
          ST_DATA: begin
            ackN = 1'b1;
            if (byteIdx == 2'd0) begin
              cmd.loadPtr = 1'b1;
              idxN = 2'd1;
            end else if (byteIdx == 2'd1) begin
              cmd.loadVal = 1'b1;
              idxN = 2'd2;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st           <= ST_IDLE;
      bitCnt       <= '0;
      byteIdx      <= '0;
      ackPhase     <= 1'b0;
      startInPulse <= 1'b0;
      sclP         <= 1'b1;
      sdaP         <= 1'b1;
    end else begin
      st           <= stN;
      bitCnt       <= bitN;
      byteIdx      <= idxN;
      ackPhase     <= ackN;
      startInPulse <= sipN;
      sclP         <= sclF;
      sdaP         <= sdaF;
    end
  end

  // Long SCL-low detection for the hardware-strap state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
      hwMode <= 1'b0;
    end else if (sclF) begin
      lowCnt <= '0;
      hwMode <= 1'b0;
    end else if (lowCnt != LW'(HW_TIMEOUT)) begin
      lowCnt <= lowCnt + 1'b1;
    end else begin
      hwMode <= 1'b1;
    end
  end

  assign sdaPullLow = ackPhase;
endmodule

// File: rtl/i2cw_reg_file.sv
module i2cw_reg_file
  import i2cw_pkg::*;
#(
  parameter int         NUM_GAIN = 4,
  parameter logic [7:0] GAIN_RST = 8'h0B,
  parameter logic [7:0] MODE_RST = 8'h00
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCmd_t                cmd,
  output logic [7:0]            rxByte,
  output logic [NUM_GAIN*8-1:0] gainOut,
  output logic [7:0]            modeOut
);
  localparam int NUM_REGS = NUM_GAIN + 1;

  logic [7:0] shiftQ, ptrQ, valQ;
  logic       pendQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      ptrQ   <= '0;
      valQ   <= '0;
      pendQ  <= 1'b0;
    end else begin
      if (cmd.shiftEn) shiftQ <= {shiftQ[6:0], cmd.bitIn};
      if (cmd.loadPtr) ptrQ <= shiftQ;
      if (cmd.loadVal) valQ <= shiftQ;
      if (cmd.commit || cmd.dropPend) pendQ <= 1'b0;
      else if (cmd.loadVal)           pendQ <= 1'b1;
    end
  end

  assign rxByte = shiftQ;

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    localparam logic [7:0] RST_VAL = (gi < NUM_GAIN) ? GAIN_RST : MODE_RST;
    logic [7:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= RST_VAL;
      else if (cmd.commit && pendQ && ptrQ == 8'(gi)) q <= valQ;
    end
    if (gi < NUM_GAIN) begin : g_gain
      assign gainOut[gi*8 +: 8] = q;
    end else begin : g_mode
      assign modeOut = q;
    end
  end
endmodule

// File: rtl/i2cw_slave.sv
module i2cw_slave
  import i2cw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h20,
  parameter int         NUM_GAIN   = 4,
  parameter logic [7:0] GAIN_RST   = 8'h0B,
  parameter logic [7:0] MODE_RST   = 8'h00,
  parameter int         FILT_LEN   = 6,
  parameter int         HW_TIMEOUT = 2000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaPullLow,
  output logic                  hwMode,
  output logic [NUM_GAIN*8-1:0] gainOut,
  output logic [7:0]            modeOut
);
  logic [1:0] rawLine, filtLine;
  logic       sclF, sdaF;
  logic [7:0] rxByte;
  dpCmd_t     cmd;

  assign rawLine = {sdaIn, sclIn};

  for (genvar li = 0; li < 2; li++) begin : g_filt
    i2cw_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rstN(rstN), .lineIn(rawLine[li]), .lineOut(filtLine[li])
    );
  end

  assign sclF = filtLine[0];
  assign sdaF = filtLine[1];

  i2cw_bus_ctrl #(.DEV_ADDR(DEV_ADDR), .HW_TIMEOUT(HW_TIMEOUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclF(sclF), .sdaF(sdaF), .rxByte(rxByte),
    .cmd(cmd), .sdaPullLow(sdaPullLow), .hwMode(hwMode)
  );

  i2cw_reg_file #(.NUM_GAIN(NUM_GAIN), .GAIN_RST(GAIN_RST), .MODE_RST(MODE_RST)) u_regs (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rxByte(rxByte),
    .gainOut(gainOut), .modeOut(modeOut)
  );
endmodule

// File: rtl/i2cw_slave_chk.sv
module i2cw_slave_chk #(
  parameter int NUM_GAIN = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclF,
  input logic                  sdaF,
  input logic                  sdaPullLow,
  input logic                  hwMode,
  input logic [NUM_GAIN*8-1:0] gainOut,
  input logic [7:0]            modeOut
);
  logic sclQ, sdaQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclF;
      sdaQ <= sdaF;
    end
  end

  assert_regs_at_stop_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({modeOut, gainOut}) |-> $past(sclF && sclQ && sdaF && !sdaQ));

  assert_ack_start_scl_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclF);

  assert_ack_end_scl_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaPullLow) |-> !sclF);

  assert_release_in_hw_R9: assert property (@(posedge clk) disable iff (!rstN)
    hwMode |=> !sdaPullLow);

  assert_hw_needs_scl_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hwMode) |-> !sclF);
endmodule

bind i2cw_slave i2cw_slave_chk #(.NUM_GAIN(NUM_GAIN)) u_chk (
  .clk(clk), .rstN(rstN), .sclF(sclF), .sdaF(sdaF), .sdaPullLow(sdaPullLow),
  .hwMode(hwMode), .gainOut(gainOut), .modeOut(modeOut)
);

// File: tb/i2cw_slave_tb.sv
module i2cw_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 32;
  localparam int FILT_LEN   = 6;
  localparam int HW_TIMEOUT = 2000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaBus;
  logic sdaPullLow, hwMode;
  logic [31:0] gainOut;
  logic [7:0]  modeOut;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdaBus = sdaM & ~sdaPullLow;

  i2cw_slave #(.FILT_LEN(FILT_LEN), .HW_TIMEOUT(HW_TIMEOUT)) u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaPullLow(sdaPullLow), .hwMode(hwMode), .gainOut(gainOut), .modeOut(modeOut)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] mdl [5];

  // Scoreboard
  logic [39:0] expQ [$];
  string       tagQ [$];
  logic [39:0] obsData;
  event        obsEv;

  initial begin
    forever begin
      @(obsEv);
      begin
        logic [39:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (obsData !== e) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", t, obsData, e);
        end
      end
    end
  end

  task automatic observe(input string tag, input logic [39:0] exp, input logic [39:0] act);
    tagQ.push_back(tag);
    expQ.push_back(exp);
    obsData = act;
    -> obsEv;
    @(negedge clk);
  endtask

  function automatic logic [39:0] snap();
    return {mdl[4], mdl[3], mdl[2], mdl[1], mdl[0]};
  endfunction

  task automatic checkRegs(input string tag);
    observe(tag, snap(), {modeOut, gainOut});
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ(); waitQ();
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; waitQ(); sclM = 1'b1; waitQ(); waitQ(); sclM = 1'b0; waitQ();
  endtask

  // Ack must be low just after SCL rises and just before it falls
  task automatic sendByte(input string tag, input logic [7:0] b, input logic expAck);
    logic early, late;
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; waitQ(); sclM = 1'b1;
    repeat (2) @(negedge clk);
    early = ~sdaBus;
    repeat (2*Q - 3) @(negedge clk);
    late = ~sdaBus;
    @(negedge clk); sclM = 1'b0; waitQ();
    observe(tag, 40'(expAck ? 2'b11 : 2'b00), 40'({early, late}));
  endtask

  task automatic readByte(output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ();
      b = {b[6:0], sdaBus};
      waitQ(); sclM = 1'b0; waitQ();
    end
    sendBit(1'b1);
  endtask

  task automatic writeReg(input logic [7:0] ptr, input logic [7:0] val);
    busStart();
    sendByte("R2 address ack", 8'h40, 1'b1);
    sendByte("R2 pointer ack", ptr, 1'b1);
    sendByte("R2 value ack", val, 1'b1);
    checkRegs("R3 no change before STOP");
    busStop();
    if (ptr < 8'd5) mdl[ptr[2:0]] = val;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rb;
    for (int i = 0; i < 4; i++) mdl[i] = 8'h0B;
    mdl[4] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    checkRegs("R1 reset values");
    observe("R1 released and strap low", 40'd0, 40'({sdaPullLow, hwMode}));

    // R3 R11 gain write, MSB first
    writeReg(8'h03, 8'h3C);
    checkRegs("R3 R11 gain3 after STOP");
    writeReg(8'h04, 8'hA5);
    checkRegs("R11 mode after STOP");
    writeReg(8'h00, 8'h81);
    checkRegs("R11 gain0 bit order");

    // R2 foreign address
    busStart();
    sendByte("R2 foreign address nack", 8'h42, 1'b0);
    sendByte("R2 byte after nack", 8'h01, 1'b0);
    sendByte("R2 byte after nack", 8'h66, 1'b0);
    busStop();
    checkRegs("R2 foreign write no effect");

    // R5 pointer out of range
    writeReg(8'h07, 8'h5A);
    checkRegs("R5 out-of-range pointer discarded");

    // R4 read request
    busStart();
    sendByte("R4 read address ack", 8'h41, 1'b1);
    readByte(rb);
    observe("R4 read returns ones", 40'hFF, 40'(rb));
    busStop();
    checkRegs("R4 read leaves registers");

    // R6 repeated START drops pending
    busStart();
    sendByte("R6 address ack", 8'h40, 1'b1);
    sendByte("R6 pointer ack", 8'h01, 1'b1);
    sendByte("R6 value ack", 8'h55, 1'b1);
    busStart();
    sendByte("R6 address after Sr", 8'h40, 1'b1);
    busStop();
    checkRegs("R6 pending dropped by Sr");

    // R7 STOP in same high pulse as START ignored
    sdaM = 1'b1; sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sdaM = 1'b1; waitQ();
    sclM = 1'b0; waitQ();
    sendByte("R7 transfer continues", 8'h40, 1'b1);
    sendByte("R7 pointer ack", 8'h01, 1'b1);
    sendByte("R7 value ack", 8'h77, 1'b1);
    busStop();
    mdl[1] = 8'h77;
    checkRegs("R7 write after ignored STOP");

    // R8 short SDA spike with SCL high
    busStart();
    sendByte("R8 address ack", 8'h40, 1'b1);
    sendByte("R8 pointer ack", 8'h02, 1'b1);
    sendByte("R8 value ack", 8'h99, 1'b1);
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ();
    sdaM = 1'b0; repeat (FILT_LEN/2) @(negedge clk); sdaM = 1'b1;
    waitQ(); sclM = 1'b0; waitQ();
    busStop();
    mdl[2] = 8'h99;
    checkRegs("R8 spike ignored, write kept");

    // R9 hardware-strap state mid-transfer
    busStart();
    sendByte("R9 address ack", 8'h40, 1'b1);
    sendByte("R9 pointer ack", 8'h00, 1'b1);
    sendByte("R9 value ack", 8'h11, 1'b1);
    for (int i = 0; i < 6; i++) begin
      sdaM = ~sdaM;
      repeat (HW_TIMEOUT/4) @(negedge clk);
    end
    observe("R9 strap flag set, line released", 40'h2, 40'({hwMode, sdaPullLow}));
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ();
    observe("R9 strap flag cleared", 40'h0, 40'(hwMode));
    sdaM = 1'b1; waitQ(); waitQ();
    checkRegs("R9 pending dropped in strap state");
    writeReg(8'h00, 8'hC3);
    checkRegs("R9 transfers after strap state");

    done = 1'b1;
    repeat (10) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule